// File: doc/BRIEF.md
# Two-Wire Debug Port Master

This block drives the debug port of a small microcontroller target over three lines: a clock that idles low, an active-low target reset, and one data line that both sides take turns driving. A host-side controller hands it one of three operations. The first is a debug-entry sequence. The second is a debug-exit reset pulse. The third is a command frame. A frame has a command byte, zero to three argument bytes and zero to two reply bytes. The block does not interpret command codes. Codes such as halt, resume, set-PC with two address bytes, or execute-instruction with its length in the low two bits all travel as an opaque command byte with the right argument and reply counts.

A programmable divider sets each half period of the debug clock, so the clock can be kept under the target's limit of about 30 MHz whatever the system clock is. Outgoing bits are shifted out most-significant bit first. The block sets each bit just after a falling clock edge, and the target latches it on the rising edge. When the outgoing bytes are done, the block releases the data line. It then samples each reply bit as it drives the clock low. It takes the line back only after the last reply bit has been captured.

Top module: `dbg2w_master`

## Requirements
- R1: After reset the block is idle. busy_o=0, done_o=0, dbg_clk_o=0, dbg_rst_no=1, dbg_data_oe_o=1 and dbg_data_o=0, and these line levels hold whenever busy_o is 0.
- R2: An entry request holds dbg_rst_no low, gives exactly two positive clock pulses while it is low, and then drives it high. done_o pulses when the sequence ends.
- R3: An exit request pulses dbg_rst_no low and back high with no clock pulse. done_o pulses when the pulse ends.
- R4: Each high and low phase of dbg_clk_o lasts div_i+1 clk_i cycles. div_i is captured when the operation is accepted. dbg_data_o and dbg_data_oe_o change only while dbg_clk_o is low.
- R5: A frame shifts out 8*(1+frame_nargs_i) bits, MSB first. The command byte comes first. Argument byte k (k=0,1,2) comes next and is taken from frame_args_i[23-8k:16-8k].
- R6: Reply bits are sampled on falling clock edges and shifted in MSB first. With one reply byte, reply_o={8'h00, byte}. With two, reply_o={first byte, second byte}. With none, reply_o=0.
- R7: dbg_data_oe_o is 0 for exactly the reply clock pulses and 1 for all outgoing pulses. It returns to 1 when the last reply bit is sampled.
- R8: busy_o is 1 from the cycle after acceptance until done_o. done_o is a one-cycle pulse in which busy_o is already 0. Requests made while busy_o is 1 are dropped.
- R9: A frame_nreply_i value of 3 is treated as 2.
- R10: When several requests are raised together, entry wins over exit, and exit wins over a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Half-period length minus one, in clk_i cycles |
| entry_req_i | input | 1 | Request the debug-entry sequence |
| exit_req_i | input | 1 | Request the debug-exit reset pulse |
| frame_valid_i | input | 1 | Request a command frame |
| frame_cmd_i | input | 8 | Command byte |
| frame_args_i | input | 24 | Argument bytes, first byte in bits 23:16 |
| frame_nargs_i | input | 2 | Number of argument bytes (0 to 3) |
| frame_nreply_i | input | 2 | Number of reply bytes (0 to 2, 3 acts as 2) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse at the end of an operation |
| reply_o | output | 16 | Captured reply bytes |
| dbg_clk_o | output | 1 | Debug clock to target |
| dbg_rst_no | output | 1 | Target reset, active low |
| dbg_data_o | output | 1 | Outgoing data value |
| dbg_data_oe_o | output | 1 | Data line output enable |
| dbg_data_i | input | 1 | Incoming data from the shared line |

## Verification
A bit or byte counter that is off by one shows up at the port as a frame with the wrong number of clock pulses. It also shifts where the output enable falls relative to the pulses, so the captured word is misaligned, and all of this is visible by the first done_o. A wrong turnaround state shows as the output enable changing while the clock is high. It can also show as the enable still low once the frame has ended, which is detected on that same clock phase. Divider faults show as a clock-high width other than div_i+1 on the first pulse of an operation. Sequencer faults show as the wrong pulse count with reset held low.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MAX_ARGS  = 3;
  localparam int unsigned MAX_REPLY = 2;
  localparam int unsigned TX_W      = BYTE_W * (MAX_ARGS + 1);
  localparam int unsigned RX_W      = BYTE_W * MAX_REPLY;
  localparam int unsigned OUT_CNT_W = $clog2(TX_W + 1);
  localparam int unsigned IN_CNT_W  = $clog2(RX_W + 1);
  localparam int unsigned ENTRY_PULSES = 2;
  localparam int unsigned ENTRY_HALVES = 2 * ENTRY_PULSES + 1;
  localparam int unsigned EXIT_HALVES  = 2;
  localparam int unsigned SEQ_CNT_W    = $clog2(ENTRY_HALVES + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_EXIT,
    ST_XFER
  } seq_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0]          cmd;
    logic [BYTE_W*MAX_ARGS-1:0] args;
    logic [1:0]                 nargs;
    logic [1:0]                 nreply;
  } frame_t;
endpackage

// File: rtl/dbg2w_tick.sv
module dbg2w_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || cnt_q == div_i) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == div_i);
endmodule

// File: rtl/dbg2w_shift.sv
module dbg2w_shift
  import dbg2w_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  frame_t          frame_i,
  input  logic            step_i,
  input  logic            data_i,
  output logic            data_o,
  output logic            oe_o,
  output logic [RX_W-1:0] reply_o,
  output logic            last_o
);
  logic [TX_W-1:0]      tx_q;
  logic [RX_W-1:0]      rx_q;
  logic [OUT_CNT_W-1:0] out_left_q;
  logic [IN_CNT_W-1:0]  in_left_q;
  logic                 oe_q;
  logic [1:0]           nrep_c;
  logic                 writing;

  // reply count clamp
  assign nrep_c  = (frame_i.nreply > 2'(MAX_REPLY)) ? 2'(MAX_REPLY) : frame_i.nreply;
  assign writing = (out_left_q != '0);
  assign last_o  = step_i && (writing ? (out_left_q == OUT_CNT_W'(1) && in_left_q == '0)
                                      : (in_left_q == IN_CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q       <= '0;
      rx_q       <= '0;
      out_left_q <= '0;
      in_left_q  <= '0;
      oe_q       <= 1'b1;
    end else if (load_i) begin
      tx_q       <= {frame_i.cmd, frame_i.args};
      rx_q       <= '0;
      out_left_q <= OUT_CNT_W'(BYTE_W * (int'(frame_i.nargs) + 1));
      in_left_q  <= IN_CNT_W'(BYTE_W * int'(nrep_c));
      oe_q       <= 1'b1;
    end else if (step_i) begin
      if (writing) begin
        tx_q       <= {tx_q[TX_W-2:0], 1'b0};
        out_left_q <= out_left_q - 1'b1;
        if (out_left_q == OUT_CNT_W'(1) && in_left_q != '0) oe_q <= 1'b0;
      end else begin
        rx_q      <= {rx_q[RX_W-2:0], data_i};
        in_left_q <= in_left_q - 1'b1;
      end
      if (last_o) begin
        oe_q <= 1'b1;
        tx_q <= '0;
      end
    end
  end

  assign data_o  = oe_q & tx_q[TX_W-1];
  assign oe_o    = oe_q;
  assign reply_o = rx_q;
endmodule

// File: rtl/dbg2w_ctrl.sv
module dbg2w_ctrl
  import dbg2w_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic entry_req_i,
  input  logic exit_req_i,
  input  logic frame_valid_i,
  input  logic tick_i,
  input  logic last_i,
  output logic start_o,
  output logic load_o,
  output logic step_o,
  output logic run_o,
  output logic busy_o,
  output logic done_o,
  output logic dbg_clk_o,
  output logic dbg_rst_no
);
  seq_state_e           state_q;
  logic [SEQ_CNT_W-1:0] hcnt_q;
  logic                 clk_q, rst_n_q, done_q;
  logic                 idle;

  assign idle    = (state_q == ST_IDLE);
  assign start_o = idle && (entry_req_i || exit_req_i || frame_valid_i);
  assign load_o  = idle && !entry_req_i && !exit_req_i && frame_valid_i;
  assign step_o  = (state_q == ST_XFER) && tick_i && clk_q;
  assign run_o   = !idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      clk_q   <= 1'b0;
      rst_n_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          hcnt_q <= '0;
          clk_q  <= 1'b0;
          if (entry_req_i) begin
            state_q <= ST_ENTRY;
            rst_n_q <= 1'b0;
          end else if (exit_req_i) begin
            state_q <= ST_EXIT;
            rst_n_q <= 1'b0;
          end else if (frame_valid_i) begin
            state_q <= ST_XFER;
          end
        end
        ST_ENTRY: if (tick_i) begin
          if (hcnt_q == SEQ_CNT_W'(ENTRY_HALVES - 1)) begin
            state_q <= ST_IDLE;
            rst_n_q <= 1'b1;
            clk_q   <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
            clk_q  <= ~clk_q;
          end
        end
        ST_EXIT: if (tick_i) begin
          if (hcnt_q == SEQ_CNT_W'(EXIT_HALVES - 1)) begin
            state_q <= ST_IDLE;
            rst_n_q <= 1'b1;
            done_q  <= 1'b1;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        ST_XFER: if (tick_i) begin
          clk_q <= ~clk_q;
          if (step_o && last_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = !idle;
  assign done_o     = done_q;
  assign dbg_clk_o  = clk_q;
  assign dbg_rst_no = rst_n_q;
endmodule

// File: rtl/dbg2w_master.sv
module dbg2w_master
  import dbg2w_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             entry_req_i,
  input  logic             exit_req_i,
  input  logic             frame_valid_i,
  input  logic [7:0]       frame_cmd_i,
  input  logic [23:0]      frame_args_i,
  input  logic [1:0]       frame_nargs_i,
  input  logic [1:0]       frame_nreply_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [15:0]      reply_o,
  output logic             dbg_clk_o,
  output logic             dbg_rst_no,
  output logic             dbg_data_o,
  output logic             dbg_data_oe_o,
  input  logic             dbg_data_i
);
  logic [DIV_W-1:0] div_q;
  logic start, load, step, run, tick, last;
  frame_t frame;

  assign frame = '{cmd: frame_cmd_i, args: frame_args_i,
                   nargs: frame_nargs_i, nreply: frame_nreply_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (start) div_q <= div_i;
  end

  dbg2w_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  dbg2w_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .entry_req_i   (entry_req_i),
    .exit_req_i    (exit_req_i),
    .frame_valid_i (frame_valid_i),
    .tick_i        (tick),
    .last_i        (last),
    .start_o       (start),
    .load_o        (load),
    .step_o        (step),
    .run_o         (run),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .dbg_clk_o     (dbg_clk_o),
    .dbg_rst_no    (dbg_rst_no)
  );

  dbg2w_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .frame_i (frame),
    .step_i  (step),
    .data_i  (dbg_data_i),
    .data_o  (dbg_data_o),
    .oe_o    (dbg_data_oe_o),
    .reply_o (reply_o),
    .last_o  (last)
  );
endmodule

// File: rtl/dbg2w_master_chk.sv
module dbg2w_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic dbg_clk_o,
  input logic dbg_rst_no,
  input logic dbg_data_o,
  input logic dbg_data_oe_o
);
  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_clk_o && $past(dbg_clk_o)) |-> ($stable(dbg_data_o) && $stable(dbg_data_oe_o)));

  // R7
  oe_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_data_oe_o != $past(dbg_data_oe_o)) |-> !dbg_clk_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R1
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (dbg_data_oe_o && !dbg_clk_o && dbg_rst_no && !dbg_data_o));
endmodule

bind dbg2w_master dbg2w_master_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .dbg_clk_o     (dbg_clk_o),
  .dbg_rst_no    (dbg_rst_no),
  .dbg_data_o    (dbg_data_o),
  .dbg_data_oe_o (dbg_data_oe_o)
);

// File: tb/tb_dbg2w_master.sv
module tb_dbg2w_master;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  div_i = '0;
  logic        entry_req_i = 1'b0, exit_req_i = 1'b0, frame_valid_i = 1'b0;
  logic [7:0]  frame_cmd_i = '0;
  logic [23:0] frame_args_i = '0;
  logic [1:0]  frame_nargs_i = '0, frame_nreply_i = '0;
  logic        busy_o, done_o, dbg_clk_o, dbg_rst_no, dbg_data_o, dbg_data_oe_o, dbg_data_i;
  logic [15:0] reply_o;

  always #5 clk_i = ~clk_i;

  dbg2w_master dut (.*);

  int total = 0, bad = 0;

  // line monitor and reply target, sole writer of its state
  int          clr_req = 0, clr_seen = 0;
  logic [15:0] tgt_init = '0, tgt_q = '0;
  logic [31:0] sent;
  int nsent, nread, npulse, nrstlow, nrstneg, hi_cnt, hi_min, hi_max;
  logic prev_clk = 1'b0, prev_rst = 1'b1, rd_pend = 1'b0;

  assign dbg_data_i = tgt_q[15];

  always @(negedge clk_i) begin
    if (clr_req != clr_seen) begin
      clr_seen = clr_req; tgt_q = tgt_init; sent = '0;
      nsent = 0; nread = 0; npulse = 0; nrstlow = 0; nrstneg = 0;
      hi_cnt = 0; hi_min = 1 << 30; hi_max = 0; rd_pend = 1'b0;
    end
    if (dbg_clk_o) hi_cnt++;
    if (dbg_clk_o && !prev_clk) begin
      npulse++;
      if (!dbg_rst_no) nrstlow++;
      if (dbg_data_oe_o) begin sent = {sent[30:0], dbg_data_o}; nsent++; end
      else begin nread++; rd_pend = 1'b1; end
    end
    if (!dbg_clk_o && prev_clk) begin
      if (hi_cnt < hi_min) hi_min = hi_cnt;
      if (hi_cnt > hi_max) hi_max = hi_cnt;
      hi_cnt = 0;
      if (rd_pend) begin tgt_q = tgt_q << 1; rd_pend = 1'b0; end
    end
    if (!dbg_rst_no && prev_rst) nrstneg++;
    prev_clk = dbg_clk_o;
    prev_rst = dbg_rst_no;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_tx(input logic [7:0] c, input logic [23:0] a, input int na);
    logic [31:0] v = {24'h0, c};
    for (int k = 0; k < na; k++) v = (v << 8) | 32'((a >> (16 - 8 * k)) & 24'hff);
    return v;
  endfunction

  function automatic logic [15:0] exp_reply(input int nr, input logic [15:0] t);
    if (nr == 0) return 16'h0;
    if (nr == 1) return {8'h00, t[15:8]};
    return t;
  endfunction

  task automatic launch(input bit en, input bit ex, input bit fv, input logic [7:0] dv,
                        input logic [7:0] c, input logic [23:0] a, input logic [1:0] na,
                        input logic [1:0] nr, input logic [15:0] t);
    int guard = 0;
    @(negedge clk_i);
    while (busy_o && guard < 20000) begin @(negedge clk_i); guard++; end
    tgt_init = t;
    clr_req++;
    @(negedge clk_i);
    div_i = dv; frame_cmd_i = c; frame_args_i = a; frame_nargs_i = na; frame_nreply_i = nr;
    entry_req_i = en; exit_req_i = ex; frame_valid_i = fv;
    @(negedge clk_i);
    entry_req_i = 1'b0; exit_req_i = 1'b0; frame_valid_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after accept", 32'(busy_o), 1);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done_o && guard < 20000) begin @(negedge clk_i); guard++; end
    chk(done_o == 1'b1, "R8 done reached (watchdog)", 32'(done_o), 1);
  endtask

  task automatic run_frame(input logic [7:0] dv, input logic [7:0] c, input logic [23:0] a,
                           input logic [1:0] na, input logic [1:0] nr, input logic [15:0] t);
    int nre = (nr > 2) ? 2 : int'(nr);
    logic [31:0] mask, e;
    launch(1'b0, 1'b0, 1'b1, dv, c, a, na, nr, t);
    wait_done();
    mask = (na == 3) ? 32'hffff_ffff : ((32'h1 << (8 * (na + 1))) - 1);
    e = exp_tx(c, a, int'(na));
    chk(nsent == 8 * (int'(na) + 1), "R5 bit count", nsent, 8 * (int'(na) + 1));
    chk((sent & mask) == e, "R5 bits MSB first", sent & mask, e);
    chk(nread == 8 * nre, "R7 read pulses with oe low", nread, 8 * nre);
    chk(reply_o == exp_reply(nre, t), "R6 reply", reply_o, exp_reply(nre, t));
    chk(hi_min == int'(dv) + 1 && hi_max == int'(dv) + 1, "R4 half period", hi_max, int'(dv) + 1);
    chk(dbg_data_oe_o == 1'b1, "R7 oe restored", 32'(dbg_data_oe_o), 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    #23;
    // R1 reset state
    chk(!busy_o && !done_o && !dbg_clk_o && dbg_rst_no && dbg_data_oe_o && !dbg_data_o,
        "R1 reset lines", {26'h0, busy_o, done_o, dbg_clk_o, dbg_rst_no, dbg_data_oe_o, dbg_data_o}, 32'h6);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R2 entry
    launch(1'b1, 1'b0, 1'b0, 8'd2, 8'h0, 24'h0, 2'd0, 2'd0, 16'h0);
    chk(dbg_rst_no == 1'b0, "R2 reset held low", 32'(dbg_rst_no), 0);
    wait_done();
    chk(npulse == 2 && nrstlow == 2, "R2 two pulses under reset", npulse, 2);
    chk(dbg_rst_no == 1'b1, "R2 reset released", 32'(dbg_rst_no), 1);

    // R3 exit
    launch(1'b0, 1'b1, 1'b0, 8'd1, 8'h0, 24'h0, 2'd0, 2'd0, 16'h0);
    wait_done();
    chk(npulse == 0 && nrstneg == 1, "R3 reset pulse no clock", npulse, 0);

    // directed frames
    run_frame(8'd0, 8'h44, 24'h0, 2'd0, 2'd1, 16'hA5_00);     // plain command, 1 reply
    run_frame(8'd3, 8'h02, 24'h12_34_00, 2'd2, 2'd0, 16'h0);  // set-PC style
    run_frame(8'd1, 8'h57, 24'h90_AB_CD, 2'd3, 2'd1, 16'h3C_00);
    run_frame(8'd0, 8'h28, 24'h0, 2'd0, 2'd2, 16'hBE_EF);
    // R9 count 3 acts as 2
    run_frame(8'd2, 8'h68, 24'h0, 2'd0, 2'd3, 16'h81_7E);

    // random frames
    for (int i = 0; i < 24; i++) begin
      run_frame(8'($urandom_range(0, 3)), 8'($urandom), 24'($urandom), 2'($urandom),
                2'($urandom), 16'($urandom));
    end

    // R10 entry over exit over frame
    launch(1'b1, 1'b1, 1'b1, 8'd0, 8'hFF, 24'h0, 2'd0, 2'd0, 16'h0);
    wait_done();
    chk(npulse == 2 && nrstlow == 2, "R10 entry wins", npulse, 2);
    launch(1'b0, 1'b1, 1'b1, 8'd0, 8'hFF, 24'h0, 2'd0, 2'd0, 16'h0);
    wait_done();
    chk(npulse == 0 && nrstneg == 1, "R10 exit wins over frame", npulse, 0);
    repeat (10) @(negedge clk_i);
    chk(!busy_o, "R10 frame dropped", 32'(busy_o), 0);

    // R8 requests while busy dropped
    launch(1'b0, 1'b0, 1'b1, 8'd1, 8'hC3, 24'h0, 2'd0, 2'd1, 16'h5A_00);
    repeat (6) @(negedge clk_i);
    frame_cmd_i = 8'h11; frame_valid_i = 1'b1; entry_req_i = 1'b1;
    @(negedge clk_i);
    frame_valid_i = 1'b0; entry_req_i = 1'b0;
    wait_done();
    chk(nsent == 8 && sent[7:0] == 8'hC3, "R8 busy request ignored", sent[7:0], 8'hC3);
    chk(reply_o == 16'h005A, "R8 reply intact", reply_o, 16'h005A);
    repeat (12) @(negedge clk_i);
    chk(!busy_o && dbg_rst_no, "R8 no queued op", 32'(busy_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule